// File: doc/BRIEF.md
# Bus Error Counter State Manager

This block keeps the transmit error counter (TEC) and receive error counter (REC) of a node on a two-wire automotive serial bus, and from them decides the fault state of the node: error active, error passive or bus-off. The protocol engine that detects errors and completed transfers drives it with single-cycle event pulses. The block answers with the counter values, the status bits and single-cycle interrupt pulses.

A programmable warning limit gives software an early signal before the node turns passive. The limit can be changed only while the node is held in reset mode. When a transmit error would push the TEC past its top value, the node goes bus-off. The block then loads fixed counter values, forces reset mode and freezes both counters. A recovery-complete pulse from the protocol engine ends the bus-off state.

The counters, the status bits and the interrupt pulses all take their new values at the same clock edge that samples the event. The asynchronous active-low reset is released synchronously inside the block, two clock edges after the pin goes high.

Top module: `bus_fault_ctl`

## Requirements
- R1: After reset, TEC and REC are 0, the warning limit is 96, reset mode is 1, and warning, passive, bus-off and both interrupt outputs are 0. The fault state output is 0.
- R2: A transmit error adds 8 to TEC and a receive error adds 1 to REC. A successful transmit or receive takes 1 from its own counter and stops at 0. If an error and a success for the same counter arrive in one cycle, the error wins.
- R3: REC saturates at 255. A receive error at 255 leaves REC at 255.
- R4: The warning bit is 1 when TEC or REC is greater than or equal to the limit, and 0 when both are below it. It takes its new value at the same edge as the counter or limit change that causes it.
- R5: A write to the warning limit takes effect only while reset mode is 1. Otherwise the write is ignored and the limit read back is unchanged.
- R6: The passive bit is 1 when TEC or REC exceeds 127. The passive interrupt pulses for one cycle on every change of the passive bit, in either direction.
- R7: The warning interrupt pulses for one cycle whenever the warning bit or the bus-off bit changes.
- R8: A transmit error that would take TEC above 255 enters bus-off. At that edge TEC becomes 127, REC becomes 0, the bus-off bit becomes 1, reset mode becomes 1 and the fault state becomes 2.
- R9: While the node is bus-off, error and success events do not change either counter. A recovery pulse during bus-off clears TEC and the bus-off bit. A recovery pulse outside bus-off has no effect.
- R10: A reset-mode set pulse sets reset mode and a clear pulse clears it. If both arrive in one cycle, set wins.
- R11: The fault state output encodes 0 for active, 1 for passive and 2 for bus-off. Bus-off takes precedence over passive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_i | input | 1 | Transmit error event pulse |
| rx_err_i | input | 1 | Receive error event pulse |
| tx_ok_i | input | 1 | Successful transmit event pulse |
| rx_ok_i | input | 1 | Successful receive event pulse |
| recover_i | input | 1 | Bus-off recovery complete pulse |
| mode_set_i | input | 1 | Request to enter reset mode |
| mode_clr_i | input | 1 | Request to leave reset mode |
| lim_we_i | input | 1 | Warning limit write strobe |
| lim_wdata_i | input | 8 | Warning limit write value |
| tec_o | output | 8 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| lim_o | output | 8 | Current warning limit |
| reset_mode_o | output | 1 | Reset mode flag |
| warn_o | output | 1 | Warning status bit |
| passive_o | output | 1 | Error passive status bit |
| busoff_o | output | 1 | Bus-off status bit |
| state_o | output | 2 | Fault state: 0 active, 1 passive, 2 bus-off |
| warn_irq_o | output | 1 | Warning/bus-off change interrupt pulse |
| pass_irq_o | output | 1 | Active/passive change interrupt pulse |

## Verification
The bench builds the block with its default parameters: 8-bit counters, a transmit step of 8, a receive step of 1, a passive threshold of 127 and a limit reset value of 96. With these values bus-off is reached after 32 transmit errors and REC saturation after 255 receive errors, so every threshold crossing fits into a short directed run. The bench also lowers the limit to small values, which moves the warning crossing into only a few receive events.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  typedef enum logic [1:0] {
    FS_ACTIVE  = 2'd0,
    FS_PASSIVE = 2'd1,
    FS_BUSOFF  = 2'd2
  } fault_state_e;
endpackage

// File: rtl/bfc_err_cnt.sv
module bfc_err_cnt #(
  parameter int unsigned W        = 8,
  parameter int unsigned STEP     = 1,
  parameter bit          SATURATE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic         hold_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o,
  output logic         over_o
);
  localparam logic [W-1:0] MAXV  = '1;
  localparam logic [W:0]   STEPV = (W+1)'(STEP);

  logic [W-1:0] cnt_q;
  logic [W:0]   sum;
  logic [W-1:0] over_val;
  logic         en;

  assign sum    = {1'b0, cnt_q} + STEPV;
  assign over_o = inc_i & sum[W];

  generate
    if (SATURATE) begin : g_sat
      assign over_val = MAXV;
    end else begin : g_wrap
      assign over_val = sum[W-1:0];
    end
  endgenerate

  always_comb begin
    nxt_o = cnt_q;
    if (load_i)                     nxt_o = load_val_i;
    else if (hold_i)                nxt_o = cnt_q;
    else if (inc_i)                 nxt_o = over_o ? over_val : sum[W-1:0];
    else if (dec_i && cnt_q != '0)  nxt_o = cnt_q - 1'b1;
  end

  assign en = load_i | (~hold_i & (inc_i | dec_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;

  // R3: a saturating counter never wraps past its top
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (SATURATE && cnt_q == MAXV && inc_i && !hold_i && !load_i) |=> (cnt_o == MAXV));
  // R2: a decrement at zero stays at zero
  a_r2_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && dec_i && !inc_i && !hold_i && !load_i) |=> (cnt_o == '0));
endmodule

// File: rtl/bfc_status.sv
module bfc_status #(
  parameter int unsigned W        = 8,
  parameter int unsigned PASS_LIM = 127
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tec_nxt_i,
  input  logic [W-1:0] rec_nxt_i,
  input  logic [W-1:0] lim_nxt_i,
  input  logic         busoff_nxt_i,
  input  logic         busoff_q_i,
  output logic         warn_o,
  output logic         passive_o,
  output logic         warn_irq_o,
  output logic         pass_irq_o
);
  localparam logic [W-1:0] PLIM = W'(PASS_LIM);

  logic warn_q, warn_n, pass_q, pass_n, wirq_q, wirq_n, pirq_q, pirq_n;

  always_comb begin
    warn_n = (tec_nxt_i >= lim_nxt_i) | (rec_nxt_i >= lim_nxt_i);
    pass_n = (tec_nxt_i > PLIM) | (rec_nxt_i > PLIM);
    wirq_n = (warn_n != warn_q) | (busoff_nxt_i != busoff_q_i);
    pirq_n = (pass_n != pass_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
      pass_q <= 1'b0;
      wirq_q <= 1'b0;
      pirq_q <= 1'b0;
    end else begin
      warn_q <= warn_n;
      pass_q <= pass_n;
      wirq_q <= wirq_n;
      pirq_q <= pirq_n;
    end
  end

  assign warn_o     = warn_q;
  assign passive_o  = pass_q;
  assign warn_irq_o = wirq_q;
  assign pass_irq_o = pirq_q;

  // R6: every change of the passive bit comes with a passive interrupt
  a_r6_pass_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pass_q) |-> pirq_q);
  // R7: every change of the warning bit comes with a warning interrupt
  a_r7_warn_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(warn_q) |-> wirq_q);
endmodule

// File: rtl/bus_fault_ctl.sv
module bus_fault_ctl #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned TX_STEP    = 8,
  parameter int unsigned RX_STEP    = 1,
  parameter int unsigned PASS_LIM   = 127,
  parameter int unsigned WARN_RESET = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err_i,
  input  logic             rx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             recover_i,
  input  logic             mode_set_i,
  input  logic             mode_clr_i,
  input  logic             lim_we_i,
  input  logic [CNT_W-1:0] lim_wdata_i,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic [CNT_W-1:0] lim_o,
  output logic             reset_mode_o,
  output logic             warn_o,
  output logic             passive_o,
  output logic             busoff_o,
  output logic [1:0]       state_o,
  output logic             warn_irq_o,
  output logic             pass_irq_o
);
  import bfc_pkg::*;

  localparam logic [CNT_W-1:0] LIM_RST  = CNT_W'(WARN_RESET);
  localparam logic [CNT_W-1:0] TEC_BOFF = CNT_W'(PASS_LIM);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic             busoff_q, busoff_n, mode_q, mode_n;
  logic [CNT_W-1:0] lim_q, lim_n;
  logic             lim_en, tec_over, enter_boff, leave_boff;
  logic             tec_load;
  logic [CNT_W-1:0] tec_load_val, tec_nxt, rec_nxt;
  logic             rec_over_unused;

  assign enter_boff   = ~busoff_q & tx_err_i & tec_over;
  assign leave_boff   = busoff_q & recover_i;
  assign tec_load     = enter_boff | leave_boff;
  assign tec_load_val = enter_boff ? TEC_BOFF : '0;

  bfc_err_cnt #(.W(CNT_W), .STEP(TX_STEP), .SATURATE(1'b0)) u_tec (
    .clk(clk), .rst_n(rst_ni),
    .inc_i(tx_err_i), .dec_i(tx_ok_i), .hold_i(busoff_q),
    .load_i(tec_load), .load_val_i(tec_load_val),
    .cnt_o(tec_o), .nxt_o(tec_nxt), .over_o(tec_over)
  );

  bfc_err_cnt #(.W(CNT_W), .STEP(RX_STEP), .SATURATE(1'b1)) u_rec (
    .clk(clk), .rst_n(rst_ni),
    .inc_i(rx_err_i), .dec_i(rx_ok_i), .hold_i(busoff_q),
    .load_i(enter_boff), .load_val_i('0),
    .cnt_o(rec_o), .nxt_o(rec_nxt), .over_o(rec_over_unused)
  );

  always_comb begin
    busoff_n = busoff_q;
    if (enter_boff)      busoff_n = 1'b1;
    else if (leave_boff) busoff_n = 1'b0;

    mode_n = mode_q;
    if (enter_boff || mode_set_i) mode_n = 1'b1;
    else if (mode_clr_i)          mode_n = 1'b0;

    lim_en = lim_we_i & mode_q;
    lim_n  = lim_en ? lim_wdata_i : lim_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busoff_q <= 1'b0;
      mode_q   <= 1'b1;
      lim_q    <= LIM_RST;
    end else begin
      busoff_q <= busoff_n;
      mode_q   <= mode_n;
      if (lim_en) lim_q <= lim_n;
    end
  end

  bfc_status #(.W(CNT_W), .PASS_LIM(PASS_LIM)) u_status (
    .clk(clk), .rst_n(rst_ni),
    .tec_nxt_i(tec_nxt), .rec_nxt_i(rec_nxt), .lim_nxt_i(lim_n),
    .busoff_nxt_i(busoff_n), .busoff_q_i(busoff_q),
    .warn_o(warn_o), .passive_o(passive_o),
    .warn_irq_o(warn_irq_o), .pass_irq_o(pass_irq_o)
  );

  fault_state_e st;
  always_comb begin
    if (busoff_q)       st = FS_BUSOFF;
    else if (passive_o) st = FS_PASSIVE;
    else                st = FS_ACTIVE;
  end

  assign state_o      = st;
  assign busoff_o     = busoff_q;
  assign reset_mode_o = mode_q;
  assign lim_o        = lim_q;

  // R8: bus-off entry loads the fixed counter values and reset mode
  a_r8_boff_entry: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busoff_q) |-> (tec_o == TEC_BOFF && rec_o == '0 && mode_q));
  // R9: counters frozen while bus-off lasts
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_ni)
    (busoff_q && !recover_i) |=> ($stable(tec_o) && $stable(rec_o)));
  // R5: limit locked outside reset mode
  a_r5_lim_locked: assert property (@(posedge clk) disable iff (!rst_ni)
    (!mode_q && lim_we_i) |=> $stable(lim_o));
  // R4: warning bit agrees with counters and limit
  a_r4_warn_match: assert property (@(posedge clk) disable iff (!rst_ni)
    warn_o == ((tec_o >= lim_o) || (rec_o >= lim_o)));
endmodule

// File: tb/bus_fault_ctl_tb_top.sv
module bus_fault_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0, recover = 0;
  logic       mset = 0, mclr = 0, lwe = 0;
  logic [7:0] lwd = '0;
  logic [7:0] tec, rec, lim;
  logic       rmode, warn, pass, boff, wirq, pirq;
  logic [1:0] st;
  int         n_chk = 0, n_bad = 0;
  int         cyc = 0;

  always #2 clk = ~clk;

  bus_fault_ctl dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_err_i(tx_err), .rx_err_i(rx_err), .tx_ok_i(tx_ok), .rx_ok_i(rx_ok),
    .recover_i(recover), .mode_set_i(mset), .mode_clr_i(mclr),
    .lim_we_i(lwe), .lim_wdata_i(lwd),
    .tec_o(tec), .rec_o(rec), .lim_o(lim), .reset_mode_o(rmode),
    .warn_o(warn), .passive_o(pass), .busoff_o(boff), .state_o(st),
    .warn_irq_o(wirq), .pass_irq_o(pirq)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; recover = 0;
    mset = 0; mclr = 0; lwe = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", tec, 0, "tec"); chk("R1", rec, 0, "rec"); chk("R1", lim, 96, "limit");
    chk("R1", rmode, 1, "reset mode"); chk("R1", warn, 0, "warn");
    chk("R1", pass, 0, "passive"); chk("R1", boff, 0, "busoff");
    chk("R1", wirq + pirq, 0, "irqs"); chk("R11", st, 0, "state");
  endtask

  task automatic t_counts();
    do_reset();
    tx_err = 1; step(); chk("R2", tec, 8, "tec +8");
    repeat (3) begin rx_err = 1; step(); end
    chk("R2", rec, 3, "rec +1 x3");
    tx_ok = 1; step(); chk("R2", tec, 7, "tec -1");
    repeat (5) begin rx_ok = 1; step(); end
    chk("R2", rec, 0, "rec floors at 0");
    tx_err = 1; tx_ok = 1; step(); chk("R2", tec, 15, "error beats success");
  endtask

  task automatic t_thresholds();
    do_reset();
    repeat (11) begin tx_err = 1; step(); end
    chk("R4", tec, 88, "tec"); chk("R4", warn, 0, "warn below limit");
    tx_err = 1; step();
    chk("R4", warn, 1, "warn at 96"); chk("R7", wirq, 1, "warn irq rise");
    step(); chk("R7", wirq, 0, "warn irq one cycle");
    repeat (4) begin tx_err = 1; step(); end
    chk("R6", tec, 128, "tec"); chk("R6", pass, 1, "passive above 127");
    chk("R6", pirq, 1, "pass irq rise"); chk("R11", st, 1, "state passive");
    tx_ok = 1; step();
    chk("R6", pass, 0, "active at 127"); chk("R6", pirq, 1, "pass irq fall");
    repeat (32) begin tx_ok = 1; step(); end
    chk("R4", tec, 95, "tec"); chk("R4", warn, 0, "warn cleared below limit");
    chk("R7", wirq, 1, "warn irq fall");
  endtask

  task automatic t_limit();
    do_reset();
    mclr = 1; step(); chk("R10", rmode, 0, "mode cleared");
    lwe = 1; lwd = 8'd10; step(); chk("R5", lim, 96, "write ignored outside reset mode");
    mset = 1; step(); chk("R10", rmode, 1, "mode set");
    lwe = 1; lwd = 8'd10; step(); chk("R5", lim, 10, "write in reset mode");
    repeat (9) begin rx_err = 1; step(); end
    chk("R4", warn, 0, "rec 9 below 10");
    rx_err = 1; step(); chk("R4", warn, 1, "rec 10 reaches limit");
    lwe = 1; lwd = 8'd20; step();
    chk("R4", warn, 0, "limit raised"); chk("R7", wirq, 1, "irq on limit change");
    mset = 1; mclr = 1; step(); chk("R10", rmode, 1, "set wins over clear");
  endtask

  task automatic t_rec_sat();
    do_reset();
    repeat (260) begin rx_err = 1; step(); end
    chk("R3", rec, 255, "rec saturates"); chk("R6", pass, 1, "passive by rec");
    chk("R11", st, 1, "state passive");
  endtask

  task automatic t_busoff();
    do_reset();
    mclr = 1; step();
    repeat (5) begin rx_err = 1; step(); end
    repeat (31) begin tx_err = 1; step(); end
    chk("R8", tec, 248, "tec before busoff"); chk("R8", boff, 0, "not yet busoff");
    tx_err = 1; step();
    chk("R8", tec, 127, "tec forced"); chk("R8", rec, 0, "rec forced");
    chk("R8", boff, 1, "busoff"); chk("R8", rmode, 1, "reset mode forced");
    chk("R11", st, 2, "state busoff"); chk("R7", wirq, 1, "irq on busoff");
    chk("R6", pirq, 1, "passive left"); chk("R4", warn, 1, "warn at 127");
    tx_err = 1; rx_err = 1; step();
    chk("R9", tec, 127, "tec frozen"); chk("R9", rec, 0, "rec frozen");
    tx_ok = 1; step(); chk("R9", tec, 127, "tec frozen on success");
    recover = 1; step();
    chk("R9", tec, 0, "tec cleared"); chk("R9", boff, 0, "busoff cleared");
    chk("R7", wirq, 1, "irq on recovery"); chk("R11", st, 0, "state active");
    tx_err = 1; step(); recover = 1; step();
    chk("R9", tec, 8, "recover outside busoff ignored");
    chk("R9", boff, 0, "busoff stays 0");
  endtask

  initial begin
    t_reset();
    t_counts();
    t_thresholds();
    t_limit();
    t_rec_sat();
    t_busoff();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule